// File: doc/BRIEF.md
# Mealy Manchester Line Encoder

This block turns a raw serial bit stream into a Manchester-coded line. Its clock runs at twice the raw bit rate, so every bit cell covers two encoder clock cycles. A one-cycle strobe, `cell_start`, marks the first clock of each raw cell. On that cycle the encoder samples `raw_bit` and keeps a copy of it.

Each bit is encoded with a level change in the middle of its output cell. A 1 goes from low to high and a 0 goes from high to low. When two neighbouring bits have the same value, the line also changes level at the boundary between their cells. Nothing extra is needed to produce that boundary edge: it follows from pre-setting the first-half level of each cell.

The next line level is a Mealy function of the state and the live input. That level is captured in a single output flop, so the output cell starts exactly one encoder clock after the input cell. This is half a bit cell of latency. `raw_bit` is assumed to be synchronous to `clk` already, so there are no synchronizer stages on it.

Top module: `manchester_enc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `enc_out` goes low after that edge and the encoder returns to its idle first-half state. After reset is released, `enc_out` stays low until a `cell_start` strobe is accepted.
- R2: An accepted strobe that samples `raw_bit` = 1 gives `enc_out` = 0 for one clock cycle, and then `enc_out` = 1 for the next clock cycle.
- R3: An accepted strobe that samples `raw_bit` = 0 gives `enc_out` = 1 for one clock cycle, and then `enc_out` = 0 for the next clock cycle.
- R4: The first-half level appears exactly one clock after the strobe cycle. During the strobe cycle itself, `enc_out` keeps its previous value.
- R5: The second-half level is the bit latched on the strobe cycle. A change of `raw_bit` during the second-half cycle has no effect on `enc_out`.
- R6: A `cell_start` that is high during a second-half cycle is ignored. It neither restarts a cell nor changes `enc_out`.
- R7: If no strobe comes after a second-half cycle, `enc_out` holds the last level it drove for as long as strobes stay absent.
- R8: Two back-to-back cells with equal bits produce a level change at their shared boundary. Two back-to-back cells with different bits produce no change there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock, twice the raw bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_start | input | 1 | One-cycle strobe on the first clock of a raw cell |
| raw_bit | input | 1 | Raw serial data, synchronous to clk |
| enc_out | output | 1 | Manchester-coded serial line |

## Verification
The bound checker follows which strobes are accepted using only the ports. On every cycle it checks the two-cycle level pattern that follows each accepted strobe for both bit values. It also checks that the line holds while no strobe is accepted, and that the line is low after reset. The bench's scenarios are what show that input toggles and stray strobes in the second half are ignored. They also show that the boundary edge appears only for equal neighbouring bits, and that a reset in the middle of a cell abandons it cleanly. The vector table walks back-to-back and gapped cells.

// File: rtl/mce_pkg.sv
// Shared types for the Manchester encoder.
// Assumes: two encoder clocks per raw bit cell.
package mce_pkg;
    // Phase of the current raw cell as seen by the encoder state machine.
    typedef enum logic {
        PH_IDLE   = 1'b0,   // waiting for a strobe (first half next)
        PH_SECOND = 1'b1    // second-half cycle of an accepted cell
    } phase_t;
endpackage

// File: rtl/mce_phase_fsm.sv
// Phase state machine: accepts a cell strobe only in the idle phase,
// latches the sampled raw bit and walks into the second half.
// Assumes raw_bit and cell_start are synchronous to clk.
module mce_phase_fsm
    import mce_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cell_start,
    input  logic   raw_bit,
    output phase_t phase,
    output logic   bit_q,
    output logic   accept
);
    phase_t phase_q;
    phase_t phase_d;

    // Accept a strobe only when not inside a second half.
    always_comb begin
        accept = cell_start && (phase_q == PH_IDLE);
    end

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (accept) phase_d = PH_SECOND;
            PH_SECOND: phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Latch the raw bit on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (accept) bit_q <= raw_bit;
    end

    assign phase = phase_q;
endmodule

// File: rtl/mce_out_stage.sv
// Output stage: Mealy next-level function registered into one flop.
// The first half is pre-set from the live bit (inverted), the second
// half replays the latched bit, otherwise the line holds.
module mce_out_stage
    import mce_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   accept,
    input  logic   raw_bit,
    input  phase_t phase,
    input  logic   bit_q,
    output logic   line_q
);
    logic line_d;

    // Mealy next level from state and live input.
    always_comb begin
        line_d = line_q;
        if (phase == PH_SECOND) line_d = bit_q;
        else if (accept)        line_d = ~raw_bit;
    end

    // Line register, low after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_d;
    end
endmodule

// File: rtl/manchester_enc.sv
// Top of the Manchester line encoder. One clock of latency from the
// strobe cycle to the first-half level; clock is twice the bit rate.
module manchester_enc
    import mce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cell_start,
    input  logic raw_bit,
    output logic enc_out
);
    phase_t phase;
    logic   bit_q;
    logic   accept;

    mce_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .raw_bit    (raw_bit),
        .phase      (phase),
        .bit_q      (bit_q),
        .accept     (accept)
    );

    mce_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .raw_bit (raw_bit),
        .phase   (phase),
        .bit_q   (bit_q),
        .line_q  (enc_out)
    );
endmodule

// File: rtl/mce_checker.sv
// Port-level checker for manchester_enc. It rebuilds strobe acceptance
// from the ports alone and checks the line pattern around each cell.
module mce_checker (
    input logic clk,
    input logic rst_n,
    input logic cell_start,
    input logic raw_bit,
    input logic enc_out
);
    logic acc_q;
    logic acc_now;

    assign acc_now = cell_start && !acc_q;

    // Track whether the previous cycle was an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= 1'b0;
        else        acc_q <= acc_now;
    end

    AST_RESET_LOW:   assert property (@(posedge clk) !rst_n |=> !enc_out); // R1
    AST_ONE_FIRST:   assert property (@(posedge clk) disable iff (!rst_n) (acc_now && raw_bit) |=> !enc_out); // R2
    AST_ZERO_FIRST:  assert property (@(posedge clk) disable iff (!rst_n) (acc_now && !raw_bit) |=> enc_out); // R3
    AST_ONE_SECOND:  assert property (@(posedge clk) disable iff (!rst_n) (acc_now && raw_bit) |=> ##1 enc_out); // R5
    AST_ZERO_SECOND: assert property (@(posedge clk) disable iff (!rst_n) (acc_now && !raw_bit) |=> ##1 !enc_out); // R5
    AST_HOLD_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) (!acc_now && !acc_q) |=> $stable(enc_out)); // R7
endmodule

bind manchester_enc mce_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .raw_bit    (raw_bit),
    .enc_out    (enc_out)
);

// File: tb/tb_manchester_enc.sv
`timescale 1ns/1ps
module tb_manchester_enc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_start = 1'b0;
    logic raw_bit = 1'b0;
    logic enc_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic last_out = 1'b0;
    logic prev_bit = 1'b0;
    logic prev_valid = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    manchester_enc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .raw_bit    (raw_bit),
        .enc_out    (enc_out)
    );

    // Vector: {gap[1:0], stray_strobe, glitch, bit}
    localparam int NV = 12;
    localparam logic [4:0] VEC [NV] = '{
        5'b00_0_0_1, 5'b00_0_0_1, 5'b00_0_0_0, 5'b00_0_0_0,
        5'b00_0_1_1, 5'b00_1_0_0, 5'b01_0_0_1, 5'b00_1_1_1,
        5'b10_0_1_0, 5'b00_0_0_1, 5'b11_1_1_0, 5'b00_0_0_0
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Starts at a negedge, returns at a negedge with cell_start low.
    task automatic send_cell(input logic b, input logic glitch, input logic stray);
        cell_start = 1'b1;
        raw_bit    = b;
        #1;
        check(enc_out, last_out, "R4 strobe cycle keeps level");
        @(negedge clk);
        check(enc_out, ~b, b ? "R2 first half" : "R3 first half");
        if (prev_valid) begin
            if (prev_bit == b) check(enc_out != last_out, 1'b1, "R8 boundary edge equal bits");
            else               check(enc_out != last_out, 1'b0, "R8 no boundary edge");
        end
        cell_start = stray;
        raw_bit    = glitch ? ~b : b;
        @(negedge clk);
        check(enc_out, b, stray ? "R6 stray strobe ignored" : (glitch ? "R5 glitch ignored" : "R2/R3 second half"));
        cell_start = 1'b0;
        raw_bit    = ~b;
        last_out   = b;
        prev_bit   = b;
        prev_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(enc_out, last_out, "R7 hold without strobe");
        end
        prev_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(enc_out, 1'b0, "R1 reset level");
        rst_n = 1'b1;
        @(negedge clk);
        check(enc_out, 1'b0, "R1 low after release");
        idle(3);
        check(enc_out, 1'b0, "R1 still low before strobe");

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][4:3] != 2'd0) idle(int'(VEC[v][4:3]));
            send_cell(VEC[v][0], VEC[v][1], VEC[v][2]);
        end
        idle(4);

        // Mid-cell reset: first half of a zero, then reset.
        cell_start = 1'b1;
        raw_bit    = 1'b0;
        @(negedge clk);
        check(enc_out, 1'b1, "R3 first half before reset");
        cell_start = 1'b0;
        rst_n      = 1'b0;
        @(negedge clk);
        check(enc_out, 1'b0, "R1 mid-cell reset");
        rst_n    = 1'b1;
        last_out = 1'b0;
        prev_valid = 1'b0;
        idle(3);
        send_cell(1'b1, 1'b0, 1'b0);
        send_cell(1'b0, 1'b0, 1'b1);
        idle(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule